// File: doc/BRIEF.md
# Eight-bit ALU with shifter

This block is the arithmetic core of a small accumulator-style microcontroller. It is a combinational datapath with a 6-bit operation code. Its first operand comes from a register. Its second operand is either a second register value or an 8-bit constant taken from the low byte of the instruction word. It returns an 8-bit result and a result-write enable for the register file. It also holds a carry flag and a zero flag in registers, which are updated at the clock edge on which an operation executes.

The surrounding sequencer presents one operation per cycle and raises `exec_en` during the cycle in which that operation is to take effect. The result and the write enable are valid in that same cycle. The flags change at the closing clock edge. The block never stalls: there is no back-pressure, and an operation offered with `exec_en` high always completes in one cycle. The carry-using operations and the carry-fed shift variants read the flag value stored before the edge.

The constant byte also carries the shift sub-field. Bits [3:1] choose one of eight shift encodings, and bit 0 gives the fill value for the two constant-fill variants. Counting the two fill values separately, there are ten shift and rotate variants.

Top module: `alu8_core`

## Requirements
- R1: After reset both the carry flag and the zero flag read 0.
- R2: Opcode bit 0 selects the second operand. A value of 0 selects `imm`, and 1 selects `opnd_b`.
- R3: Opcodes 000000 and 000001 (load) return the second operand with `res_we` high and leave both flags unchanged.
- R4: Opcodes 00101x (AND), 00110x (OR) and 00111x (XOR) return the bitwise result with `res_we` high, clear carry, and set zero when the result is 0.
- R5: Opcodes 01001x (test) keep `res_we` low. They set zero when (A AND B) is 0, and set carry to the odd parity (XOR reduction) of A AND B.
- R6: Opcodes 01010x (compare) keep `res_we` low. They set carry when A is less than B (unsigned borrow of A minus B) and set zero when A equals B.
- R7: Opcodes 01100x (add) and 01101x (add with carry) return A+B, or A+B+C for the carry form, modulo 256. They set carry to the carry out, and zero on an all-zero result.
- R8: Opcodes 01110x (subtract) and 01111x (subtract with carry) return A-B, or A-B-C for the carry form, modulo 256. They set carry to the borrow out, and zero on an all-zero result.
- R9: Opcode 100000 with `imm[3]`=0 shifts A left by one and sends A[7] to carry. The bit entering at the LSB depends on `imm[2:1]`: 00 takes the stored carry, 01 takes A[7] (rotate), 10 takes A[0], and 11 takes `imm[0]`.
- R10: Opcode 100000 with `imm[3]`=1 shifts A right by one and sends A[0] to carry. The bit entering at the MSB depends on `imm[2:1]`: 00 takes the stored carry, 01 takes A[7], 10 takes A[0] (rotate), and 11 takes `imm[0]`.
- R11: When `exec_en` is low, or the opcode is not listed in R3 to R10, both flags hold and `res_we` is low.
- R12: After every result-writing operation, the zero flag is 1 exactly when the written result was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| exec_en | input | 1 | Operation takes effect in this cycle |
| opcode | input | 6 | Operation code |
| opnd_a | input | 8 | First operand (register) |
| opnd_b | input | 8 | Second register operand |
| imm | input | 8 | Instruction constant; also the shift sub-field and fill bit |
| result | output | 8 | Operation result |
| res_we | output | 1 | Result is to be written back |
| flag_c | output | 1 | Stored carry flag |
| flag_z | output | 1 | Stored zero flag |

## Verification
The bench targets the carry boundaries. FF+01 must produce a zero result with carry set, and 00-01 must produce a borrow. A carry-in form run with the stored carry set must differ from the plain form by one. A design that ignored the stored carry, or inverted the borrow sense, would show a result or flag that is off by one. Every shift encoding is applied to 81h and to 7Eh, so that a swapped fill source or a wrong carry-out bit becomes visible. Test and compare are followed by a check that no write occurred and that the flags match the parity and equality rules. Load, idle cycles and undefined opcodes are checked for unchanged flags, which a design that updated flags for every opcode would disturb.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  // Opcode bits [5:1]; bit 0 picks the second operand
  typedef enum logic [4:0] {
    GRP_LOAD  = 5'b00000,
    GRP_AND   = 5'b00101,
    GRP_OR    = 5'b00110,
    GRP_XOR   = 5'b00111,
    GRP_TEST  = 5'b01001,
    GRP_COMP  = 5'b01010,
    GRP_ADD   = 5'b01100,
    GRP_ADDC  = 5'b01101,
    GRP_SUB   = 5'b01110,
    GRP_SUBC  = 5'b01111,
    GRP_SHIFT = 5'b10000
  } op_grp_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_XOR = 2'd2
  } log_sel_e;
endpackage

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]      a,
  input  logic [DW-1:0]      b,
  input  alu8_pkg::log_sel_e sel,
  output logic [DW-1:0]      y
);
  import alu8_pkg::*;
  always_comb begin
    unique case (sel)
      LOG_OR:  y = a | b;
      LOG_XOR: y = a ^ b;
      default: y = a & b;
    endcase
  end
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic          use_cin,
  input  logic          cin,
  output logic [DW-1:0] y,
  output logic          cout
);
  localparam int EW = DW + 1;
  logic [EW-1:0] ext;
  logic          c_eff;
  always_comb begin
    c_eff = use_cin & cin;
    if (sub) ext = {1'b0, a} - {1'b0, b} - EW'(c_eff);
    else     ext = {1'b0, a} + {1'b0, b} + EW'(c_eff);
    y    = ext[DW-1:0];
    cout = ext[DW];
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic          cin,
  input  logic [3:0]    ctl,   // [3] right, [2:1] entering-bit source, [0] fill
  output logic [DW-1:0] y,
  output logic          cout
);
  logic fill;
  always_comb begin
    unique case (ctl[2:1])
      2'b00:   fill = cin;
      2'b01:   fill = a[DW-1];
      2'b10:   fill = a[0];
      default: fill = ctl[0];
    endcase
    if (ctl[3]) begin
      y    = {fill, a[DW-1:1]};
      cout = a[0];
    end else begin
      y    = {a[DW-2:0], fill};
      cout = a[DW-1];
    end
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic c_in,
  input  logic z_in,
  output logic c_q,
  output logic z_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else if (upd) begin
      c_q <= c_in;
      z_q <= z_in;
    end
  end

  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(c_q) && $stable(z_q)));
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic [5:0]    opcode,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [DW-1:0] imm,
  output logic [DW-1:0] result,
  output logic          res_we,
  output logic          flag_c,
  output logic          flag_z
);
  import alu8_pkg::*;

  logic [DW-1:0] b_sel, log_y, as_y, sh_y;
  logic          as_c, sh_c, as_sub, as_cin;
  log_sel_e      lsel;
  logic          wr, upd, c_nxt, z_nxt, known;
  logic [4:0]    grp;

  assign grp   = opcode[5:1];
  assign b_sel = opcode[0] ? opnd_b : imm;

  alu8_logic #(.DW(DW)) u_log (.a(opnd_a), .b(b_sel), .sel(lsel), .y(log_y));
  alu8_addsub #(.DW(DW)) u_as (.a(opnd_a), .b(b_sel), .sub(as_sub),
    .use_cin(as_cin), .cin(flag_c), .y(as_y), .cout(as_c));
  alu8_shift #(.DW(DW)) u_sh (.a(opnd_a), .cin(flag_c), .ctl(imm[3:0]),
    .y(sh_y), .cout(sh_c));

  always_comb begin
    lsel   = LOG_AND;
    as_sub = 1'b0;
    as_cin = 1'b0;
    result = '0;
    wr     = 1'b0;
    known  = 1'b1;
    c_nxt  = flag_c;
    z_nxt  = flag_z;
    case (grp)
      GRP_LOAD: begin result = b_sel; wr = 1'b1; known = 1'b0; end
      GRP_AND, GRP_OR, GRP_XOR: begin
        lsel   = (grp == GRP_OR) ? LOG_OR : (grp == GRP_XOR) ? LOG_XOR : LOG_AND;
        result = log_y;
        wr     = 1'b1;
        c_nxt  = 1'b0;
        z_nxt  = (log_y == '0);
      end
      GRP_TEST: begin
        c_nxt = ^log_y;
        z_nxt = (log_y == '0);
      end
      GRP_COMP: begin
        as_sub = 1'b1;
        c_nxt  = as_c;
        z_nxt  = (as_y == '0);
      end
      GRP_ADD, GRP_ADDC, GRP_SUB, GRP_SUBC: begin
        as_sub = grp[1];
        as_cin = grp[0];
        result = as_y;
        wr     = 1'b1;
        c_nxt  = as_c;
        z_nxt  = (as_y == '0);
      end
      GRP_SHIFT: begin
        if (!opcode[0]) begin
          result = sh_y;
          wr     = 1'b1;
          c_nxt  = sh_c;
          z_nxt  = (sh_y == '0);
        end else known = 1'b0;
      end
      default: known = 1'b0;
    endcase
  end

  assign res_we = exec_en & wr;
  assign upd    = exec_en & known;

  alu8_flags u_flags (.clk(clk), .rst_n(rst_n), .upd(upd), .c_in(c_nxt),
    .z_in(z_nxt), .c_q(flag_c), .z_q(flag_z));

  // R5
  test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && grp == GRP_TEST) |-> !res_we);
  // R6
  comp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && grp == GRP_COMP) |-> !res_we);
  // R4
  logic_clears_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (grp == GRP_AND || grp == GRP_OR || grp == GRP_XOR)) |=> !flag_c);
  // R3
  load_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && grp == GRP_LOAD) |=> ($stable(flag_c) && $stable(flag_z)));
  // R9
  left_shift_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && opcode == 6'b100000 && !imm[3]) |=> (flag_c == $past(opnd_a[DW-1])));
  // R12
  zero_tracks_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && grp != GRP_LOAD) |=> (flag_z == ($past(result) == '0)));
endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_en = 1'b0;
  logic [5:0] opcode = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0, imm = '0;
  logic [7:0] result;
  logic       res_we, flag_c, flag_z;
  int         n_vec = 0, n_bad = 0;
  logic       m_c = 1'b0, m_z = 1'b0;

  always #4 clk = ~clk;

  alu8_core uut (.clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .result(result),
    .res_we(res_we), .flag_c(flag_c), .flag_z(flag_z));

  function automatic string tag_of(input logic [5:0] op);
    case (op[5:1])
      5'b00000: return "R3";
      5'b00101, 5'b00110, 5'b00111: return "R4";
      5'b01001: return "R5";
      5'b01010: return "R6";
      5'b01100, 5'b01101: return "R7";
      5'b01110, 5'b01111: return "R8";
      5'b10000: return op[0] ? "R11" : "R9/R10";
      default: return "R11";
    endcase
  endfunction

  // Reference: result, write, update, next carry, next zero
  function automatic void model(input logic en, input logic [5:0] op,
      input logic [7:0] a, input logic [7:0] rb, input logic [7:0] k,
      input logic c, input logic z, output logic [7:0] r, output logic we,
      output logic nc, output logic nz);
    logic [7:0] b;
    logic [8:0] t;
    logic       f;
    b = op[0] ? rb : k; // R2
    r = 8'h00; we = 1'b0; nc = c; nz = z;
    case (op[5:1])
      5'b00000: begin r = b; we = 1'b1; end
      5'b00101: begin r = a & b; we = 1'b1; nc = 1'b0; nz = (r == 0); end
      5'b00110: begin r = a | b; we = 1'b1; nc = 1'b0; nz = (r == 0); end
      5'b00111: begin r = a ^ b; we = 1'b1; nc = 1'b0; nz = (r == 0); end
      5'b01001: begin nz = ((a & b) == 0); nc = ^(a & b); end
      5'b01010: begin nc = (a < b); nz = (a == b); end
      5'b01100, 5'b01101: begin
        t = 9'(a) + 9'(b) + 9'(op[1] & c);
        r = t[7:0]; we = 1'b1; nc = t[8]; nz = (r == 0);
      end
      5'b01110, 5'b01111: begin
        t = 9'(a) - 9'(b) - 9'(op[1] & c);
        r = t[7:0]; we = 1'b1; nc = t[8]; nz = (r == 0);
      end
      5'b10000: if (!op[0]) begin
        case (k[2:1])
          2'b00: f = c;
          2'b01: f = a[7];
          2'b10: f = a[0];
          default: f = k[0];
        endcase
        if (k[3]) begin r = {f, a[7:1]}; nc = a[0]; end
        else      begin r = {a[6:0], f}; nc = a[7]; end
        we = 1'b1; nz = (r == 0);
      end
      default: ;
    endcase
    if (!en) begin we = 1'b0; nc = c; nz = z; end
  endfunction

  task automatic chk(input string tag, input string what, input logic [8:0] act,
                     input logic [8:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic en, input logic [5:0] op, input logic [7:0] a,
                       input logic [7:0] rb, input logic [7:0] k);
    logic [7:0] r;
    logic we, nc, nz;
    string tg;
    @(negedge clk);
    exec_en = en; opcode = op; opnd_a = a; opnd_b = rb; imm = k;
    model(en, op, a, rb, k, m_c, m_z, r, we, nc, nz);
    tg = en ? tag_of(op) : "R11";
    #1;
    chk(tg, "res_we", 9'(res_we), 9'(we));
    if (we) chk(tg, "result", 9'(result), 9'(r));
    @(negedge clk);
    m_c = nc; m_z = nz;
    chk(tg, "flags", {7'd0, flag_c, flag_z}, {7'd0, m_c, m_z});
    exec_en = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [5:0] ops [11];
    ops = '{6'b000000, 6'b001010, 6'b001100, 6'b001110, 6'b010010,
            6'b010100, 6'b011000, 6'b011010, 6'b011100, 6'b011110, 6'b100000};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "flags", {7'd0, flag_c, flag_z}, 9'd0);
    rst_n = 1'b1;
    // R2 operand select
    apply(1, 6'b000000, 8'h00, 8'h55, 8'hA3);
    apply(1, 6'b000001, 8'h00, 8'h55, 8'hA3);
    // R7 carry boundary, then carry-in form
    apply(1, 6'b011000, 8'hFF, 8'h00, 8'h01);
    apply(1, 6'b011010, 8'h10, 8'h00, 8'h05);
    // R8 borrow and borrow-in
    apply(1, 6'b011100, 8'h00, 8'h00, 8'h01);
    apply(1, 6'b011110, 8'h10, 8'h00, 8'h05);
    // R6 compare equal / less
    apply(1, 6'b010101, 8'h3C, 8'h3C, 8'h00);
    apply(1, 6'b010100, 8'h02, 8'h00, 8'h09);
    // R5 test parity
    apply(1, 6'b010010, 8'hF7, 8'h00, 8'h13);
    apply(1, 6'b010011, 8'hF0, 8'h0F, 8'h00);
    // R4 logic ops clear carry, R3 load keeps flags
    apply(1, 6'b011100, 8'h00, 8'h00, 8'h01);
    apply(1, 6'b000000, 8'h00, 8'h00, 8'h00);
    apply(1, 6'b001110, 8'h5A, 8'h00, 8'h5A);
    // R9 R10 every shift encoding on two patterns, with carry both ways
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 16; s++) begin
        apply(1, 6'b011000, 8'hFF, 8'h00, p ? 8'h01 : 8'h00);
        apply(1, 6'b100000, p ? 8'h81 : 8'h7E, 8'h00, 8'(s));
      end
    // R11 idle cycles and undefined opcodes
    apply(0, 6'b011000, 8'hFF, 8'h00, 8'h01);
    apply(1, 6'b100001, 8'h81, 8'h00, 8'h00);
    apply(1, 6'b111111, 8'h00, 8'h00, 8'h00);
    apply(1, 6'b000110, 8'h00, 8'h00, 8'h00);
    // Random mix, R12 zero tracking included
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      logic [31:0] rv;
      rv = $urandom;
      if (rv[3:0] == 4'd0) op = rv[9:4];
      else op = ops[rv[7:4] % 11] | ((rv[8] && rv[7:4] % 11 != 10) ? 6'd1 : 6'd0);
      apply(rv[31:28] != 4'd0, op, 8'($urandom), 8'($urandom),
            (rv[10] ? 8'h00 : 8'($urandom)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule